// File: doc/BRIEF.md
# Thread Block Admission Controller

This block sits in front of one streaming multiprocessor and decides, in the cycle a placement request arrives, whether a new thread block can become resident. Each request gives the number of threads in the block, the registers each thread needs and the block's shared-memory footprint in bytes. The controller compares the request with the resources that resident blocks already hold. It then answers with exactly one outcome: grant, defer or reject. A deferred request may succeed later, after retirements. A rejected request cannot fit even on an idle multiprocessor.

On a grant the block takes the lowest free resident slot. It receives a contiguous register range that starts at the current bump pointer, and all running totals move at the next clock edge. A retirement names a slot and returns that slot's threads, registers and shared memory to the pools. The bump pointer does not move back until no block is resident, and it then returns to zero. Requests and decisions are combinational in the request cycle. The totals are registered.

Top module: `tba_admit_ctrl`

## Requirements
- R1: A request is granted only when all of the following hold: a resident slot is free (at most 8 slots), resident threads plus the request stay at or below 768, the bump pointer plus the register demand stays at or below 8192, and used shared memory plus the request stays at or below 16384 bytes.
- R2: Register demand equals threads times registers per thread. The register base reported on the k-th of a run of identical grants from an empty state is k times that demand. With 256 threads, 10 registers per thread gives three grants and 11 registers per thread gives two.
- R3: A deferred or rejected request leaves the resident count, the thread, register and shared-memory totals and the register base unchanged.
- R4: A granted request adds its threads, register demand, shared memory and one resident block to the totals, visible after the next rising clock edge.
- R5: A request that could never fit raises reject_o instead of defer_o. This applies to zero threads, more than 768 threads, a register demand above 8192 and shared memory above 16384 bytes.
- R6: Retiring an occupied slot subtracts that slot's stored threads, registers and shared memory and one block from the totals. Retiring a free slot changes nothing.
- R7: The register bump pointer never reuses a freed range while any block stays resident. A request that fits in live registers but not above the pointer is deferred. When the last block retires, the pointer returns to 0.
- R8: A grant takes the lowest-numbered free slot, reported on slot_o.
- R9: After reset every total, the resident count and the register base are zero.
- R10: At most one of grant_o, defer_o and reject_o is high, and none is high without req_valid_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Placement request present |
| req_threads_i | input | 11 | Threads in the requested block |
| req_rpt_i | input | 8 | Registers per thread |
| req_smem_i | input | 16 | Shared-memory bytes for the block |
| retire_i | input | 1 | A resident block finishes |
| retire_slot_i | input | 3 | Slot of the finishing block |
| grant_o | output | 1 | Request admitted this cycle |
| defer_o | output | 1 | Request does not fit now |
| reject_o | output | 1 | Request can never fit |
| slot_o | output | 3 | Slot given on grant |
| reg_base_o | output | 14 | Register bump pointer; base of a granted range |
| blocks_o | output | 4 | Resident block count |
| threads_o | output | 10 | Resident thread total |
| regs_o | output | 14 | Live register total |
| smem_o | output | 15 | Used shared-memory bytes |

## Verification
The assertions assume that req_valid_i and retire_i are never high in the same cycle when a defer or grant is checked against the totals. The stable-state and increment properties therefore exclude cycles with a retirement. The bench never drives both strobes together. It changes inputs only on falling edges, so each request is judged against settled totals. Retirements always name slots whose contents the bench tracks, except for the deliberate retirement of a free slot.

// File: rtl/tba_pkg.sv
package tba_pkg;
  typedef enum logic [1:0] {
    DEC_NONE   = 2'd0,
    DEC_GRANT  = 2'd1,
    DEC_DEFER  = 2'd2,
    DEC_REJECT = 2'd3
  } decision_e;
endpackage

// File: rtl/tba_fit_check.sv
module tba_fit_check
  import tba_pkg::*;
#(
  parameter int MAX_THREADS = 768,
  parameter int NUM_REGS    = 8192,
  parameter int SMEM_BYTES  = 16384,
  parameter int REQ_THR_W   = 11,
  parameter int RPT_W       = 8,
  parameter int REQ_SMEM_W  = 16,
  parameter int THR_W       = 10,
  parameter int REG_W       = 14,
  parameter int SMEM_W      = 15,
  localparam int DEM_W      = REQ_THR_W + RPT_W
) (
  input  logic [REQ_THR_W-1:0]  threads_i,
  input  logic [RPT_W-1:0]      rpt_i,
  input  logic [REQ_SMEM_W-1:0] smem_i,
  input  logic                  any_free_i,
  input  logic [THR_W-1:0]      threads_used_i,
  input  logic [REG_W-1:0]      reg_ptr_i,
  input  logic [SMEM_W-1:0]     smem_used_i,
  output decision_e             dec_o,
  output logic [DEM_W-1:0]      demand_o
);
  localparam int CW = 32;

  logic [CW-1:0] thr_sum, reg_sum, smem_sum;
  logic          never_fits, fits_now;

  always_comb begin
    demand_o = DEM_W'(threads_i) * DEM_W'(rpt_i);
    thr_sum  = CW'(threads_used_i) + CW'(threads_i);
    reg_sum  = CW'(reg_ptr_i) + CW'(demand_o);
    smem_sum = CW'(smem_used_i) + CW'(smem_i);

    never_fits = (threads_i == '0)
              || (CW'(threads_i) > CW'(MAX_THREADS))
              || (CW'(demand_o) > CW'(NUM_REGS))
              || (CW'(smem_i) > CW'(SMEM_BYTES));

    fits_now = any_free_i
            && (thr_sum <= CW'(MAX_THREADS))
            && (reg_sum <= CW'(NUM_REGS))
            && (smem_sum <= CW'(SMEM_BYTES));

    if (never_fits)    dec_o = DEC_REJECT;
    else if (fits_now) dec_o = DEC_GRANT;
    else               dec_o = DEC_DEFER;
  end
endmodule

// File: rtl/tba_slot_table.sv
module tba_slot_table #(
  parameter int MAX_BLOCKS = 8,
  parameter int THR_W      = 10,
  parameter int REG_W      = 14,
  parameter int SMEM_W     = 15,
  localparam int SLOT_W    = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [THR_W-1:0]  alloc_threads_i,
  input  logic [REG_W-1:0]  alloc_regs_i,
  input  logic [SMEM_W-1:0] alloc_smem_i,
  input  logic              retire_i,
  input  logic [SLOT_W-1:0] retire_slot_i,
  output logic              any_free_o,
  output logic [SLOT_W-1:0] free_slot_o,
  output logic              ret_valid_o,
  output logic [THR_W-1:0]  ret_threads_o,
  output logic [REG_W-1:0]  ret_regs_o,
  output logic [SMEM_W-1:0] ret_smem_o
);
  logic [MAX_BLOCKS-1:0] busy_q;
  logic [THR_W-1:0]      thr_q  [MAX_BLOCKS];
  logic [REG_W-1:0]      reg_q  [MAX_BLOCKS];
  logic [SMEM_W-1:0]     smem_q [MAX_BLOCKS];

  // lowest free slot wins
  always_comb begin
    any_free_o  = 1'b0;
    free_slot_o = '0;
    for (int i = MAX_BLOCKS - 1; i >= 0; i--) begin
      if (!busy_q[i]) begin
        any_free_o  = 1'b1;
        free_slot_o = SLOT_W'(i);
      end
    end
  end

  always_comb begin
    ret_valid_o   = retire_i && busy_q[retire_slot_i];
    ret_threads_o = thr_q[retire_slot_i];
    ret_regs_o    = reg_q[retire_slot_i];
    ret_smem_o    = smem_q[retire_slot_i];
  end

  for (genvar s = 0; s < MAX_BLOCKS; s++) begin : g_slot
    logic take, drop;
    assign take = alloc_i && any_free_o && (free_slot_o == SLOT_W'(s));
    assign drop = ret_valid_o && (retire_slot_i == SLOT_W'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        busy_q[s] <= 1'b0;
        thr_q[s]  <= '0;
        reg_q[s]  <= '0;
        smem_q[s] <= '0;
      end else if (take) begin
        busy_q[s] <= 1'b1;
        thr_q[s]  <= alloc_threads_i;
        reg_q[s]  <= alloc_regs_i;
        smem_q[s] <= alloc_smem_i;
      end else if (drop) begin
        busy_q[s] <= 1'b0;
      end
    end
  end

  assert_alloc_free_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> any_free_o);
endmodule

// File: rtl/tba_admit_ctrl.sv
module tba_admit_ctrl
  import tba_pkg::*;
#(
  parameter int MAX_BLOCKS  = 8,
  parameter int MAX_THREADS = 768,
  parameter int NUM_REGS    = 8192,
  parameter int SMEM_BYTES  = 16384,
  parameter int REQ_THR_W   = 11,
  parameter int RPT_W       = 8,
  parameter int REQ_SMEM_W  = 16,
  localparam int SLOT_W     = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1,
  localparam int BLK_W      = $clog2(MAX_BLOCKS + 1),
  localparam int THR_W      = $clog2(MAX_THREADS + 1),
  localparam int REG_W      = $clog2(NUM_REGS + 1),
  localparam int SMEM_W     = $clog2(SMEM_BYTES + 1),
  localparam int DEM_W      = REQ_THR_W + RPT_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_valid_i,
  input  logic [REQ_THR_W-1:0]  req_threads_i,
  input  logic [RPT_W-1:0]      req_rpt_i,
  input  logic [REQ_SMEM_W-1:0] req_smem_i,
  input  logic                  retire_i,
  input  logic [SLOT_W-1:0]     retire_slot_i,
  output logic                  grant_o,
  output logic                  defer_o,
  output logic                  reject_o,
  output logic [SLOT_W-1:0]     slot_o,
  output logic [REG_W-1:0]      reg_base_o,
  output logic [BLK_W-1:0]      blocks_o,
  output logic [THR_W-1:0]      threads_o,
  output logic [REG_W-1:0]      regs_o,
  output logic [SMEM_W-1:0]     smem_o
);
  logic [BLK_W-1:0]  blocks_q, blocks_d;
  logic [THR_W-1:0]  threads_q, threads_d;
  logic [REG_W-1:0]  regs_q, regs_d, ptr_q, ptr_d;
  logic [SMEM_W-1:0] smem_q, smem_d;

  decision_e         dec;
  logic [DEM_W-1:0]  demand;
  logic              any_free, ret_valid;
  logic [SLOT_W-1:0] free_slot;
  logic [THR_W-1:0]  ret_threads;
  logic [REG_W-1:0]  ret_regs;
  logic [SMEM_W-1:0] ret_smem;

  tba_fit_check #(
    .MAX_THREADS (MAX_THREADS),
    .NUM_REGS    (NUM_REGS),
    .SMEM_BYTES  (SMEM_BYTES),
    .REQ_THR_W   (REQ_THR_W),
    .RPT_W       (RPT_W),
    .REQ_SMEM_W  (REQ_SMEM_W),
    .THR_W       (THR_W),
    .REG_W       (REG_W),
    .SMEM_W      (SMEM_W)
  ) i_fit (
    .threads_i      (req_threads_i),
    .rpt_i          (req_rpt_i),
    .smem_i         (req_smem_i),
    .any_free_i     (any_free),
    .threads_used_i (threads_q),
    .reg_ptr_i      (ptr_q),
    .smem_used_i    (smem_q),
    .dec_o          (dec),
    .demand_o       (demand)
  );

  assign grant_o  = req_valid_i && (dec == DEC_GRANT);
  assign defer_o  = req_valid_i && (dec == DEC_DEFER);
  assign reject_o = req_valid_i && (dec == DEC_REJECT);
  assign slot_o   = free_slot;

  tba_slot_table #(
    .MAX_BLOCKS (MAX_BLOCKS),
    .THR_W      (THR_W),
    .REG_W      (REG_W),
    .SMEM_W     (SMEM_W)
  ) i_slots (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .alloc_i         (grant_o),
    .alloc_threads_i (THR_W'(req_threads_i)),
    .alloc_regs_i    (REG_W'(demand)),
    .alloc_smem_i    (SMEM_W'(req_smem_i)),
    .retire_i        (retire_i),
    .retire_slot_i   (retire_slot_i),
    .any_free_o      (any_free),
    .free_slot_o     (free_slot),
    .ret_valid_o     (ret_valid),
    .ret_threads_o   (ret_threads),
    .ret_regs_o      (ret_regs),
    .ret_smem_o      (ret_smem)
  );

  always_comb begin
    blocks_d  = blocks_q;
    threads_d = threads_q;
    regs_d    = regs_q;
    smem_d    = smem_q;
    ptr_d     = ptr_q;
    if (grant_o) begin
      blocks_d  = blocks_d + BLK_W'(1);
      threads_d = threads_d + THR_W'(req_threads_i);
      regs_d    = regs_d + REG_W'(demand);
      smem_d    = smem_d + SMEM_W'(req_smem_i);
      ptr_d     = ptr_d + REG_W'(demand);
    end
    if (ret_valid) begin
      blocks_d  = blocks_d - BLK_W'(1);
      threads_d = threads_d - ret_threads;
      regs_d    = regs_d - ret_regs;
      smem_d    = smem_d - ret_smem;
    end
    // compact only once nothing is resident
    if (blocks_d == '0) ptr_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      blocks_q  <= '0;
      threads_q <= '0;
      regs_q    <= '0;
      smem_q    <= '0;
      ptr_q     <= '0;
    end else begin
      blocks_q  <= blocks_d;
      threads_q <= threads_d;
      regs_q    <= regs_d;
      smem_q    <= smem_d;
      ptr_q     <= ptr_d;
    end
  end

  assign blocks_o   = blocks_q;
  assign threads_o  = threads_q;
  assign regs_o     = regs_q;
  assign smem_o     = smem_q;
  assign reg_base_o = ptr_q;

  assert_one_outcome_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({grant_o, defer_o, reject_o}));

  assert_quiet_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |-> !(grant_o || defer_o || reject_o));

  assert_hold_on_refusal_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (defer_o || reject_o) && !retire_i) |=>
      ($stable(blocks_o) && $stable(threads_o) && $stable(regs_o)
       && $stable(smem_o) && $stable(reg_base_o)));

  assert_grant_adds_block_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant_o && !retire_i) |=> (blocks_o == $past(blocks_o) + BLK_W'(1)));

  assert_within_limits_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(threads_o) <= 32'(MAX_THREADS)) && (32'(reg_base_o) <= 32'(NUM_REGS))
    && (32'(smem_o) <= 32'(SMEM_BYTES)) && (32'(blocks_o) <= 32'(MAX_BLOCKS)));

  assert_empty_compacts_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (blocks_o == '0) |-> (reg_base_o == '0 && regs_o == '0));

  assert_live_below_ptr_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    regs_o <= reg_base_o);
endmodule

// File: tb/test_tba_admit_ctrl.sv
module test_tba_admit_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [10:0] req_threads_i = '0;
  logic [7:0]  req_rpt_i = '0;
  logic [15:0] req_smem_i = '0;
  logic        retire_i = 1'b0;
  logic [2:0]  retire_slot_i = '0;
  logic        grant_o, defer_o, reject_o;
  logic [2:0]  slot_o;
  logic [13:0] reg_base_o;
  logic [3:0]  blocks_o;
  logic [9:0]  threads_o;
  logic [13:0] regs_o;
  logic [14:0] smem_o;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  tba_admit_ctrl i_tba_admit_ctrl (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // outcome: 1 grant, 2 defer, 3 reject, 0 none
  int r_out, r_slot, r_base;
  task automatic do_req(input int t, input int r, input int s);
    @(negedge clk_i);
    req_valid_i = 1'b1; req_threads_i = 11'(t); req_rpt_i = 8'(r); req_smem_i = 16'(s);
    #1;
    r_out = grant_o ? 1 : defer_o ? 2 : reject_o ? 3 : 0;
    if (int'(grant_o) + int'(defer_o) + int'(reject_o) > 1) r_out = 9;
    r_slot = int'(slot_o); r_base = int'(reg_base_o);
    @(posedge clk_i); #1;
    req_valid_i = 1'b0;
  endtask

  task automatic do_retire(input int slot);
    @(negedge clk_i);
    retire_i = 1'b1; retire_slot_i = 3'(slot);
    @(posedge clk_i); #1;
    retire_i = 1'b0;
  endtask

  task automatic chk_totals(input string req, input int b, input int t,
                            input int rg, input int sm, input int base);
    chk(int'(blocks_o) == b, req, "blocks", int'(blocks_o), b);
    chk(int'(threads_o) == t, req, "threads", int'(threads_o), t);
    chk(int'(regs_o) == rg, req, "regs", int'(regs_o), rg);
    chk(int'(smem_o) == sm, req, "smem", int'(smem_o), sm);
    chk(int'(reg_base_o) == base, req, "reg_base", int'(reg_base_o), base);
  endtask

  function automatic int imin(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int thr_set[7]  = '{32, 64, 128, 256, 384, 512, 768};
    int rpt_set[5]  = '{4, 10, 11, 16, 21};
    int smem_set[4] = '{0, 2048, 6000, 16384};

    repeat (3) @(posedge clk_i);
    #1;
    // R9: reset state
    chk_totals("R9", 0, 0, 0, 0, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!(grant_o || defer_o || reject_o), "R10", "idle outcome", 1, 0);

    // sweep of identical-block fills (R1, R2, R4, R3, R5, R6, R7)
    foreach (thr_set[a]) foreach (rpt_set[b]) foreach (smem_set[c]) begin
      int t = thr_set[a];
      int r = rpt_set[b];
      int s = smem_set[c];
      int dem = t * r;
      int n;
      if (dem > 8192) begin
        do_req(t, r, s);
        chk(r_out == 3, "R5", "oversized outcome", r_out, 3);
        chk_totals("R3", 0, 0, 0, 0, 0);
      end else begin
        n = imin(8, 768 / t);
        n = imin(n, 8192 / dem);
        if (s != 0) n = imin(n, 16384 / s);
        for (int k = 0; k < n; k++) begin
          do_req(t, r, s);
          chk(r_out == 1, "R1", "grant", r_out, 1);
          chk(r_slot == k, "R8", "slot", r_slot, k);
          chk(r_base == k * dem, "R2", "reg base", r_base, k * dem);
        end
        chk_totals("R4", n, n * t, n * dem, n * s, n * dem);
        do_req(t, r, s);
        chk(r_out == 2, "R1", "defer when full", r_out, 2);
        chk_totals("R3", n, n * t, n * dem, n * s, n * dem);
        for (int k = 0; k < n; k++) do_retire(k);
        chk_totals("R6", 0, 0, 0, 0, 0);
      end
    end

    // R2: the 2560 vs 2816 register example
    for (int k = 0; k < 3; k++) do_req(256, 10, 0);
    chk(int'(blocks_o) == 3, "R2", "256x10 count", int'(blocks_o), 3);
    for (int k = 0; k < 3; k++) do_retire(k);
    for (int k = 0; k < 3; k++) do_req(256, 11, 0);
    chk(int'(blocks_o) == 2, "R2", "256x11 count", int'(blocks_o), 2);
    chk(r_out == 2, "R2", "third 256x11 deferred", r_out, 2);
    do_retire(0); do_retire(1);

    // R5: never-fitting shapes
    do_req(1024, 1, 0);
    chk(r_out == 3, "R5", "1024 threads", r_out, 3);
    do_req(0, 4, 0);
    chk(r_out == 3, "R5", "zero threads", r_out, 3);
    do_req(32, 1, 16385);
    chk(r_out == 3, "R5", "smem over pool", r_out, 3);
    chk_totals("R3", 0, 0, 0, 0, 0);

    // R6, R7, R8: slot reuse and bump pointer
    for (int k = 0; k < 3; k++) do_req(64, 8, 1000);
    do_retire(5);
    chk_totals("R6", 3, 192, 1536, 3000, 1536);
    do_retire(1);
    chk_totals("R6", 2, 128, 1024, 2000, 1536);
    do_req(64, 8, 1000);
    chk(r_out == 1 && r_slot == 1, "R8", "lowest free slot", r_slot, 1);
    chk(r_base == 1536, "R7", "no range reuse", r_base, 1536);
    chk_totals("R4", 3, 192, 1536, 3000, 2048);
    do_retire(0); do_retire(1); do_retire(2);
    chk_totals("R7", 0, 0, 0, 0, 0);

    // R7: live registers fit but pointer does not
    for (int k = 0; k < 3; k++) do_req(256, 10, 0);
    do_retire(0);
    do_req(256, 10, 0);
    chk(r_out == 2, "R7", "defer above pointer", r_out, 2);
    chk_totals("R3", 2, 512, 5120, 0, 7680);
    do_retire(1); do_retire(2);
    do_req(256, 10, 0);
    chk(r_out == 1 && r_base == 0, "R7", "base after compaction", r_base, 0);

    @(negedge clk_i);
    chk(!(grant_o || defer_o || reject_o), "R10", "idle outcome", 1, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule